// File: doc/BRIEF.md
# Vectored Interrupt Controller with Cascade and Slave Modes

This block gathers five maskable external interrupt request lines and turns them into a single vectored request to a CPU core. Each input is asynchronous, so it passes through a two-flop synchronizer first. Each line is then sensed as either a rising edge or a level. When the core accepts the request, the block answers with an 8-bit interrupt type and a one-cycle valid strobe.

Three modes are supported:

- **Master mode.** The lines feed the core directly. When several lines are active, a fixed priority picks one, and the type is built inside the block.
- **Cascade (master with slaves).** Lines 0 and 1 can each be served by an external controller. The request pins for lines 2 and 3 are then retired as inputs. In their place, two active-low acknowledge outputs ask the external device to put its type byte on the bus, and the block latches that byte.
- **Slave mode.** The block raises `irq_o` toward an external master. Line 0 becomes the master's request to this block. A low `select_n_i` means the master has put a type on the bus, and the block accepts that type only after a line-0 request has been seen.

Top module: `irq_casc_ctrl`

## Requirements
- R1: Every request input passes through two flops before it can be seen. A level line driven high just after a rising edge shows on `core_req_o` after the second following rising edge and not after the first.
- R2: A line set to edge sensing (its `edge_mode_i` bit = 1) records a rising edge of its synchronized input. The recorded request stays pending after the input falls and is cleared when that line is acknowledged.
- R3: A line set to level sensing (its `edge_mode_i` bit = 0) requests only while its synchronized input is high. If the input drops before the acknowledge, the request is lost and no vector is produced.
- R4: A line whose `mask_i` bit is 1 never raises a request. An edge that arrives while the line is masked is not kept. A level line that is still high when it is unmasked requests at once.
- R5: Among active lines, the lowest index wins. A line that is not served by an external controller gets the internal type 0x0C plus its index, which gives 0x0C for line 0 up to 0x10 for line 4.
- R6: In master mode, `core_ack_i` is taken on a rising edge while `core_req_o` is high. For an internal type, `vec_valid_o` is high for exactly one cycle, starting in the cycle that follows the accepting edge. `core_req_o` stays low while a vector is being delivered.
- R7: When line 0 (`cascade_en_i[0]`) or line 1 (`cascade_en_i[1]`) is cascaded and wins, the matching `cas_ack_n_o` bit goes low for exactly two cycles after the accepting edge. `bus_type_i` is sampled in the second of those cycles. That byte is then presented with `vec_valid_o` in the next cycle.
- R8: While `cascade_en_i[0]` is set, request line 2 is ignored. While `cascade_en_i[1]` is set, request line 3 is ignored.
- R9: In slave mode (`mode_i` = 1), `irq_o` is high while any unmasked active line among lines 1 to 4 is present. In this mode `core_req_o` stays low and both `cas_ack_n_o` bits stay high.
- R10: In slave mode, a low `select_n_i` seen at a rising edge latches `bus_type_i` and gives a one-cycle `vec_valid_o` in the next cycle. This happens only if an unmasked line-0 request has been seen since the last such transfer. Otherwise `select_n_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Asynchronous interrupt request lines, index 0 highest priority |
| mode_i | input | 1 | 0 master, 1 slave |
| cascade_en_i | input | 2 | Per-line cascade enable for lines 0 and 1 |
| edge_mode_i | input | 5 | Per-line sensing: 1 rising edge, 0 level |
| mask_i | input | 5 | Per-line mask, 1 blocks the line |
| core_ack_i | input | 1 | Core accepts the pending request |
| select_n_i | input | 1 | Slave mode: master has put a type on the bus (active low) |
| bus_type_i | input | 8 | Type byte from the external bus |
| core_req_o | output | 1 | Vectored request to the core |
| vec_valid_o | output | 1 | One-cycle strobe, type valid |
| vec_type_o | output | 8 | Interrupt type |
| cas_ack_n_o | output | 2 | Cascade acknowledges for lines 0 and 1 (active low) |
| irq_o | output | 1 | Slave mode request toward the external master |

## Verification
The assertions take for granted that the configuration inputs (`mode_i`, `cascade_en_i`, `edge_mode_i`) do not change while a vector is in flight. They also assume `select_n_i` and `bus_type_i` are synchronous to the clock. The stimulus changes configuration only while the sequencer is idle and no request is pending. It drives the bus byte and select strobe on falling edges. It holds each request at least three cycles so that every sensed edge passes the synchronizer.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK1 = 2'd1,
    ST_ACK2 = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  localparam int unsigned N_CAS = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] ff1_q, ff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= '0;
      ff2_q <= '0;
    end else begin
      ff1_q <= async_i;
      ff2_q <= ff1_q;
    end
  end

  assign sync_o = ff2_q;

  // cycles since reset, saturating, so $past never reaches before reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_two_flop_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/irq_line_sense.sv
module irq_line_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic edge_mode_i,
  input  logic mask_i,
  input  logic ignore_i,
  input  logic clr_i,
  output logic act_o
);
  logic prev_q, pend_q;
  logic rise, enable;

  assign enable = ~mask_i & ~ignore_i;
  assign rise   = sync_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      // new edge wins over a same-cycle clear
      if (edge_mode_i) pend_q <= (pend_q & ~clr_i) | (rise & enable);
      else             pend_q <= 1'b0;
    end
  end

  assign act_o = enable & (edge_mode_i ? pend_q : sync_i);

  assert_pend_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && pend_q && !clr_i) ##1 edge_mode_i |-> pend_q);
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_casc_ctrl.sv
module irq_casc_ctrl #(
  parameter int unsigned N_LINES   = 5,
  parameter int unsigned TYPE_W    = 8,
  parameter logic [7:0]  BASE_TYPE = 8'h0C,
  localparam int unsigned IW = $clog2(N_LINES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_LINES-1:0]  req_i,
  input  logic                mode_i,
  input  logic [1:0]          cascade_en_i,
  input  logic [N_LINES-1:0]  edge_mode_i,
  input  logic [N_LINES-1:0]  mask_i,
  input  logic                core_ack_i,
  input  logic                select_n_i,
  input  logic [TYPE_W-1:0]   bus_type_i,
  output logic                core_req_o,
  output logic                vec_valid_o,
  output logic [TYPE_W-1:0]   vec_type_o,
  output logic [1:0]          cas_ack_n_o,
  output logic                irq_o
);
  import irq_casc_pkg::*;

  logic               is_slave;
  logic [1:0]         cas_eff;
  logic [N_LINES-1:0] sync_req, ignore, act, clr;
  logic               any_act;
  logic [IW-1:0]      grant_idx;
  logic               take, slv_take, grant_cas;
  seq_state_e         state_q;
  logic               cas_line_q, seen_q;
  logic [TYPE_W-1:0]  type_q;

  assign is_slave = mode_i;
  assign cas_eff  = cascade_en_i & {2{~is_slave}};

  irq_sync #(.W(N_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(req_i),
    .sync_o (sync_req)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    // lines N_CAS..2*N_CAS-1 double as acknowledge pins
    if (i >= N_CAS && i < 2 * N_CAS) begin : g_shared
      assign ignore[i] = cas_eff[i-N_CAS];
    end else begin : g_plain
      assign ignore[i] = 1'b0;
    end

    assign clr[i] = (take && grant_idx == IW'(i)) || (slv_take && i == 0);

    irq_line_sense u_sense (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_i     (sync_req[i]),
      .edge_mode_i(edge_mode_i[i]),
      .mask_i     (mask_i[i]),
      .ignore_i   (ignore[i]),
      .clr_i      (clr[i]),
      .act_o      (act[i])
    );
  end

  irq_prio #(.N(N_LINES)) u_prio (
    .req_i(act),
    .any_o(any_act),
    .idx_o(grant_idx)
  );

  assign core_req_o = ~is_slave && (state_q == ST_IDLE) && any_act;
  assign take       = core_req_o && core_ack_i;
  assign grant_cas  = (grant_idx < IW'(N_CAS)) && cas_eff[grant_idx[0]];
  assign slv_take   = is_slave && (state_q == ST_IDLE) && !select_n_i && seen_q;
  assign irq_o      = is_slave && (|act[N_LINES-1:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cas_line_q <= 1'b0;
      type_q     <= '0;
      seen_q     <= 1'b0;
    end else begin
      if (!is_slave || slv_take) seen_q <= 1'b0;
      else if (act[0])           seen_q <= 1'b1;

      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            cas_line_q <= grant_idx[0];
            if (grant_cas) begin
              state_q <= ST_ACK1;
            end else begin
              type_q  <= TYPE_W'(BASE_TYPE) + TYPE_W'(grant_idx);
              state_q <= ST_DONE;
            end
          end else if (slv_take) begin
            type_q  <= bus_type_i;
            state_q <= ST_DONE;
          end
        end
        ST_ACK1: state_q <= ST_ACK2;
        ST_ACK2: begin
          type_q  <= bus_type_i;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < N_CAS; k++) begin : g_ack
    assign cas_ack_n_o[k] = !(((state_q == ST_ACK1) || (state_q == ST_ACK2))
                              && (cas_line_q == k[0]));

    assert_ack_two_cycles_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cas_ack_n_o[k]) |=> (!cas_ack_n_o[k] ##1 cas_ack_n_o[k]));

    assert_valid_after_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cas_ack_n_o[k]) |-> vec_valid_o);
  end

  assign vec_valid_o = (state_q == ST_DONE);
  assign vec_type_o  = type_q;

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);

  assert_no_ignored_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> !ignore[grant_idx]);

  assert_slave_no_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_slave && $past(is_slave)) |-> (&cas_ack_n_o));

  assert_select_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_slave && state_q == ST_IDLE && !seen_q) |=> !vec_valid_o);
endmodule

// File: tb/sim_irq_casc_ctrl.sv
module sim_irq_casc_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] req_i = '0;
  logic       mode_i = 1'b0;
  logic [1:0] cascade_en_i = '0;
  logic [4:0] edge_mode_i = '0;
  logic [4:0] mask_i = '0;
  logic       core_ack_i = 1'b0;
  logic       select_n_i = 1'b1;
  logic [7:0] bus_type_i = '0;
  logic       core_req_o, vec_valid_o, irq_o;
  logic [7:0] vec_type_o;
  logic [1:0] cas_ack_n_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  irq_casc_ctrl u0 (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // accept a request and record the delivery
  task automatic take_vec(output int nval, output int vtype, output int n0,
                          output int n1, output int busy_req);
    nval = 0; vtype = 0; n0 = 0; n1 = 0; busy_req = 0;
    core_ack_i = 1'b1;
    @(negedge clk_i);
    core_ack_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (!cas_ack_n_o[0]) n0++;
      if (!cas_ack_n_o[1]) n1++;
      if (vec_valid_o) begin nval++; vtype = vec_type_o; end
      if ((vec_valid_o || cas_ack_n_o != 2'b11) && core_req_o) busy_req++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    chk(core_req_o == 0 && vec_valid_o == 0, "R6 reset outputs", core_req_o, 0);
    chk(cas_ack_n_o == 2'b11 && irq_o == 0, "R9 reset ack/irq", cas_ack_n_o, 3);
  endtask

  task automatic t_sync_level;
    int nv, ty, a0, a1, br;
    req_i[4] = 1'b1;
    @(negedge clk_i);
    chk(core_req_o == 0, "R1 not after one edge", core_req_o, 0);
    @(negedge clk_i);
    chk(core_req_o == 1, "R1 after two edges", core_req_o, 1);
    take_vec(nv, ty, a0, a1, br);
    chk(nv == 1, "R6 one valid pulse", nv, 1);
    chk(ty == 8'h10, "R5 type line4", ty, 8'h10);
    chk(br == 0 && a0 == 0 && a1 == 0, "R6 no req while busy", br, 0);
    req_i[4] = 1'b0;
    wait_cyc(4);
    chk(core_req_o == 0, "R3 level released", core_req_o, 0);
  endtask

  task automatic t_edge;
    int nv, ty, a0, a1, br;
    edge_mode_i[2] = 1'b1;
    req_i[2] = 1'b1;
    wait_cyc(3);
    req_i[2] = 1'b0;
    wait_cyc(5);
    chk(core_req_o == 1, "R2 edge held after drop", core_req_o, 1);
    take_vec(nv, ty, a0, a1, br);
    chk(nv == 1 && ty == 8'h0E, "R2 edge vector line2", ty, 8'h0E);
    wait_cyc(2);
    chk(core_req_o == 0, "R2 cleared by ack", core_req_o, 0);
    edge_mode_i[2] = 1'b0;
  endtask

  task automatic t_level_lost;
    int nv, ty, a0, a1, br;
    req_i[1] = 1'b1;
    wait_cyc(4);
    chk(core_req_o == 1, "R3 level requesting", core_req_o, 1);
    req_i[1] = 1'b0;
    wait_cyc(4);
    chk(core_req_o == 0, "R3 dropped request gone", core_req_o, 0);
    take_vec(nv, ty, a0, a1, br);
    chk(nv == 0, "R3 no vector after loss", nv, 0);
  endtask

  task automatic t_mask;
    mask_i[3] = 1'b1;
    req_i[3] = 1'b1;
    wait_cyc(5);
    chk(core_req_o == 0, "R4 masked level", core_req_o, 0);
    mask_i[3] = 1'b0;
    @(negedge clk_i);
    chk(core_req_o == 1, "R4 unmask live level", core_req_o, 1);
    req_i[3] = 1'b0;
    wait_cyc(4);
    edge_mode_i[3] = 1'b1;
    mask_i[3] = 1'b1;
    wait_cyc(2);
    req_i[3] = 1'b1;
    wait_cyc(4);
    req_i[3] = 1'b0;
    wait_cyc(4);
    mask_i[3] = 1'b0;
    wait_cyc(2);
    chk(core_req_o == 0, "R4 masked edge not kept", core_req_o, 0);
    edge_mode_i[3] = 1'b0;
  endtask

  task automatic t_prio;
    int nv, ty, a0, a1, br;
    req_i[3] = 1'b1;
    req_i[1] = 1'b1;
    wait_cyc(4);
    take_vec(nv, ty, a0, a1, br);
    chk(ty == 8'h0D, "R5 lower index wins", ty, 8'h0D);
    req_i[1] = 1'b0;
    wait_cyc(4);
    take_vec(nv, ty, a0, a1, br);
    chk(nv == 1 && ty == 8'h0F, "R5 next line served", ty, 8'h0F);
    req_i[3] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_cas0;
    int nv, ty, a0, a1, br;
    cascade_en_i = 2'b01;
    bus_type_i = 8'hA5;
    req_i[0] = 1'b1;
    req_i[2] = 1'b1;
    wait_cyc(4);
    take_vec(nv, ty, a0, a1, br);
    chk(a0 == 2 && a1 == 0, "R7 ack0 two cycles", a0, 2);
    chk(nv == 1 && ty == 8'hA5, "R7 bus type latched", ty, 8'hA5);
    req_i[0] = 1'b0;
    wait_cyc(4);
    chk(core_req_o == 0, "R8 line2 ignored", core_req_o, 0);
    cascade_en_i = 2'b00;
    @(negedge clk_i);
    chk(core_req_o == 1, "R8 line2 back as input", core_req_o, 1);
    req_i[2] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_cas1;
    cascade_en_i = 2'b10;
    req_i[1] = 1'b1;
    req_i[3] = 1'b1;
    wait_cyc(4);
    core_ack_i = 1'b1;
    @(negedge clk_i);
    core_ack_i = 1'b0;
    bus_type_i = 8'h11;
    chk(cas_ack_n_o == 2'b01, "R7 ack1 first cycle", cas_ack_n_o, 1);
    @(negedge clk_i);
    bus_type_i = 8'h5A;
    chk(cas_ack_n_o == 2'b01, "R7 ack1 second cycle", cas_ack_n_o, 1);
    @(negedge clk_i);
    chk(vec_valid_o == 1 && vec_type_o == 8'h5A, "R7 second-cycle sample", vec_type_o, 8'h5A);
    chk(cas_ack_n_o == 2'b11, "R7 ack released", cas_ack_n_o, 3);
    @(negedge clk_i);
    chk(vec_valid_o == 0, "R6 valid single cycle", vec_valid_o, 0);
    req_i[1] = 1'b0;
    wait_cyc(4);
    chk(core_req_o == 0, "R8 line3 ignored", core_req_o, 0);
    req_i[3] = 1'b0;
    cascade_en_i = 2'b00;
    wait_cyc(4);
  endtask

  task automatic t_slave;
    int nv;
    mode_i = 1'b1;
    req_i[4] = 1'b1;
    wait_cyc(4);
    chk(irq_o == 1 && core_req_o == 0, "R9 irq out, no core req", irq_o, 1);
    chk(cas_ack_n_o == 2'b11, "R9 acks idle", cas_ack_n_o, 3);
    mask_i[4] = 1'b1;
    @(negedge clk_i);
    chk(irq_o == 0, "R9 masked line no irq", irq_o, 0);
    mask_i[4] = 1'b0;
    bus_type_i = 8'h77;
    select_n_i = 1'b0;
    nv = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      if (vec_valid_o) nv++;
    end
    select_n_i = 1'b1;
    chk(nv == 0, "R10 select before int0 ignored", nv, 0);
    req_i[0] = 1'b1;
    wait_cyc(4);
    select_n_i = 1'b0;
    @(negedge clk_i);
    select_n_i = 1'b1;
    chk(vec_valid_o == 1 && vec_type_o == 8'h77, "R10 master type taken", vec_type_o, 8'h77);
    @(negedge clk_i);
    chk(vec_valid_o == 0, "R10 single strobe", vec_valid_o, 0);
    req_i = '0;
    wait_cyc(4);
    chk(irq_o == 0, "R9 irq drops", irq_o, 0);
    mode_i = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);
    t_reset();
    t_sync_level();
    t_edge();
    t_level_lost();
    t_mask();
    t_prio();
    t_cas0();
    t_cas1();
    t_slave();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule